// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the processor-facing side of an SPI master. Software reaches it through a 32-bit register port with a request, a write flag, a byte address and write data; read data comes back from a register one cycle after the request. Behind the port it keeps the control, configuration, interrupt-enable, DMA and period/test words. It also holds a transmit queue and a receive queue of 32-bit words, builds the status word from the queue levels, raises an interrupt and drives four active-low chip selects.

The serial shifter is a separate engine. This block tells it to start with a one-cycle pulse. It gives the engine the head of the transmit queue and takes received words and an end-of-exchange strobe back from it. Clearing the enable bit by a control write acts as a full soft reset. Reading the receive register when the queue is empty returns a fixed marker word.

Register indices are the byte address divided by four:

| Index | Register |
|---|---|
| 0 | receive data |
| 1 | transmit data |
| 2 | control |
| 3 | configuration |
| 4 | interrupt enable |
| 5 | DMA |
| 6 | status |
| 7 | period |
| 8 | test |
| 9 | message data |

Control fields:

| Bits | Field |
|---|---|
| 0 | enable |
| 2 | exchange request |
| 3 | start-on-write |
| 7:4 | master mask, one bit per channel |
| 19:18 | channel select |

Status bits:

| Bit | Meaning |
|---|---|
| 0 | transmit empty |
| 1 | transmit at most half full |
| 2 | transmit full |
| 3 | receive non-empty |
| 4 | receive full |
| 5 | receive overrun |
| 6 | exchange done |

Top module: `spi_regfront`

## Requirements
- R1: Status bits track the queues on every cycle. Bit 0 is set when transmit is empty, bit 1 when the transmit level is at most half the depth, bit 2 when transmit is full, bit 3 when receive is non-empty and bit 4 when receive is full.
- R2: `irq` is high exactly when some status bit and the same interrupt-enable bit are both 1.
- R3: Writing the status register clears bit 5 and bit 6 wherever the written bit is 1. All other status bits ignore the write.
- R4: A control write with bit 0 at 0 clears every register and empties both queues. Afterwards status reads 0x00000003 and all chip selects are high. A hard reset gives the same state.
- R5: A transmit-data write is dropped while disabled or while the transmit queue is full. Otherwise it is queued in order and offered on `eng_tx_word`.
- R6: A receive-data read returns 0 while disabled and 0xDEADBEEF when the receive queue is empty. Otherwise it returns the oldest word and removes it.
- R7: Transmit data, message data, indices 10 and above, and any access with address bits 1:0 not zero all read 0. Writes to them, and to receive data, change nothing.
- R8: A control write with enable=1, where the master-mask bit of the selected channel is set, drives `cs_n[sel]` low and the other chip selects high. Any other control write leaves the chip selects unchanged.
- R9: `xfer_start` pulses one cycle after one of three writes. The first is an accepted transmit write while the selected channel is master and start-on-write is set. The second is a master control write that newly sets start-on-write while transmit is non-empty. The third is a master control write that newly sets exchange request with start-on-write 0.
- R10: `eng_done` sets status bit 6 and clears the exchange-request bit. A receive word offered while the receive queue is full is dropped and sets status bit 5.
- R11: The configuration, interrupt-enable, DMA, period and test registers read back the last value written.
- R12: Read data appears on `bus_rdata` the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| bus_valid | input | 1 | access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | registered read data |
| irq | output | 1 | interrupt, active high |
| cs_n | output | 4 | chip selects, active low |
| xfer_start | output | 1 | one-cycle start pulse to the engine |
| eng_tx_word | output | 32 | head of the transmit queue |
| eng_tx_empty | output | 1 | transmit queue empty |
| eng_tx_pop | input | 1 | engine takes the head word |
| eng_rx_push | input | 1 | engine offers a received word |
| eng_rx_word | input | 32 | received word |
| eng_done | input | 1 | exchange finished strobe |

## Verification
The embedded properties check these rules on every cycle: queue levels stay bounded, empty and full are never both set, at most one chip select is low, start pulses follow a write, and read data holds between reads. They also check that overrun stays set until it is cleared, that a disabled transmit write leaves the queue level unchanged, and that the soft reset lands in its documented state. The directed scenarios are the only place where exact data ordering is shown, along with the marker word on an empty read, half-full thresholds, interrupt masking, and overrun dropping the new word rather than the queued ones. They also cover each of the three start conditions together with the near-miss cases that must not start.

// File: rtl/spi_rf_pkg.sv
// Shared constants and types for the SPI register front end.
// Assumes a 32-bit data path and four chip-select channels.
package spi_rf_pkg;
    localparam int DATA_W = 32;
    localparam int NUM_CS = 4;
    localparam int SEL_W  = $clog2(NUM_CS);

    // Register indices (byte address / 4); software depends on these.
    localparam int REG_RX    = 0;
    localparam int REG_TX    = 1;
    localparam int REG_CTRL  = 2;
    localparam int REG_CFG   = 3;
    localparam int REG_IEN   = 4;
    localparam int REG_DMA   = 5;
    localparam int REG_STAT  = 6;
    localparam int REG_PER   = 7;
    localparam int REG_TST   = 8;
    localparam int REG_MSG   = 9;
    localparam int REG_COUNT = 10;

    // Control field positions.
    localparam int CTRL_EN       = 0;
    localparam int CTRL_XCH      = 2;
    localparam int CTRL_SMC      = 3;
    localparam int CTRL_MODE_LSB = 4;
    localparam int CTRL_SEL_LSB  = 18;

    // Status bit positions.
    localparam int STAT_TE  = 0;
    localparam int STAT_TDR = 1;
    localparam int STAT_TF  = 2;
    localparam int STAT_RR  = 3;
    localparam int STAT_RF  = 4;
    localparam int STAT_RO  = 5;
    localparam int STAT_TC  = 6;

    localparam logic [DATA_W-1:0] STAT_IDLE     = 32'h0000_0003;
    localparam logic [DATA_W-1:0] RX_EMPTY_WORD = 32'hDEAD_BEEF;

    // Decoded view of a control word.
    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [NUM_CS-1:0] mode;
        logic              smc;
        logic              xch;
        logic              en;
    } ctrl_view_t;
endpackage

// File: rtl/spi_rf_fifo.sv
// Word queue with flush, used for both transmit and receive paths.
// Pushes while full and pops while empty are ignored. Flush wins over
// push and pop. Assumes DEPTH >= 2.
module spi_rf_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = PW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (!do_push && do_pop) level <= level - 1'b1;
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R1
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R4
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (full && $stable(level))); // R5
endmodule

// File: rtl/spi_rf_status.sv
// Builds the status word from queue levels plus the two sticky bits, and
// drives the interrupt. Sticky bits: a set in the same cycle beats a
// write-one-to-clear; soft clear beats both.
module spi_rf_status
    import spi_rf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic [LW-1:0]     tx_level,
    input  logic [LW-1:0]     rx_level,
    input  logic              set_ro,
    input  logic              set_tc,
    input  logic              w1c_en,
    input  logic [1:0]        w1c_bits,   // {done, overrun}
    input  logic [DATA_W-1:0] inten,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    logic ro_q, tc_q;

    // Sticky overrun and exchange-done flags.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ro_q <= 1'b0;
            tc_q <= 1'b0;
        end else begin
            ro_q <= set_ro || (ro_q && !(w1c_en && w1c_bits[0]));
            tc_q <= set_tc || (tc_q && !(w1c_en && w1c_bits[1]));
        end
    end

    // Live status word assembled from the queue levels.
    always_comb begin
        status           = '0;
        status[STAT_TE]  = (tx_level == '0);
        status[STAT_TDR] = (tx_level <= LW'(DEPTH / 2));
        status[STAT_TF]  = (tx_level == LW'(DEPTH));
        status[STAT_RR]  = (rx_level != '0);
        status[STAT_RF]  = (rx_level == LW'(DEPTH));
        status[STAT_RO]  = ro_q;
        status[STAT_TC]  = tc_q;
    end

    assign irq = |(status & inten);

    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[STAT_TE] && status[STAT_TF])); // R1
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (inten == '0) |-> !irq); // R2
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_RO] && !(w1c_en && w1c_bits[0]) && !soft_clr)
        |=> status[STAT_RO]); // R3
endmodule

// File: rtl/spi_regfront.sv
// Register front end of an SPI master: decodes single-cycle register
// accesses, owns the transmit/receive queues, chip selects, interrupt and
// engine start pulse. Assumes the engine pops only when the queue is
// non-empty and gives eng_done one cycle per finished exchange.
module spi_regfront
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [3:0]        cs_n,
    output logic              xfer_start,
    output logic [31:0]       eng_tx_word,
    output logic              eng_tx_empty,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [31:0]       eng_rx_word,
    input  logic              eng_done
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int LW    = $clog2(FIFO_DEPTH) + 1;

    logic [IDX_W-1:0]  idx;
    logic              aligned;
    logic [REG_COUNT-1:0] hit;
    logic              rd_req, wr_req;
    logic [DATA_W-1:0] ctrl_q, cfg_q, ien_q, dma_q, per_q, tst_q;
    logic [DATA_W-1:0] rdata_q, rd_mux, stat_word;
    logic [NUM_CS-1:0] cs_q, cs_nxt;
    logic              start_q;
    ctrl_view_t        cur_v, new_v;
    logic              cur_master, new_master, enabled;
    logic              soft_clr, wr_ctrl, wr_tx, wr_stat;
    logic              tx_push, tx_accept, rx_pop, set_ro, cs_load;
    logic              st_a, st_b, st_c;
    logic [DATA_W-1:0] tx_head, rx_head;
    logic [LW-1:0]     tx_level, rx_level;
    logic              tx_empty, tx_full, rx_empty, rx_full;

    // Address decode: one hit bit per implemented register.
    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign rd_req  = bus_valid && !bus_write;
    assign wr_req  = bus_valid && bus_write;
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_hit
        assign hit[g] = aligned && (idx == IDX_W'(g));
    end

    // Control word views: current register and incoming write data.
    assign cur_v = '{sel:  ctrl_q[CTRL_SEL_LSB +: SEL_W],
                     mode: ctrl_q[CTRL_MODE_LSB +: NUM_CS],
                     smc:  ctrl_q[CTRL_SMC], xch: ctrl_q[CTRL_XCH],
                     en:   ctrl_q[CTRL_EN]};
    assign new_v = '{sel:  bus_wdata[CTRL_SEL_LSB +: SEL_W],
                     mode: bus_wdata[CTRL_MODE_LSB +: NUM_CS],
                     smc:  bus_wdata[CTRL_SMC], xch: bus_wdata[CTRL_XCH],
                     en:   bus_wdata[CTRL_EN]};
    assign cur_master = cur_v.mode[cur_v.sel];
    assign new_master = new_v.mode[new_v.sel];
    assign enabled    = cur_v.en;

    assign wr_ctrl   = wr_req && hit[REG_CTRL];
    assign wr_tx     = wr_req && hit[REG_TX];
    assign wr_stat   = wr_req && hit[REG_STAT];
    assign soft_clr  = wr_ctrl && !new_v.en;
    assign tx_push   = wr_tx && enabled;
    assign tx_accept = tx_push && !tx_full;
    assign rx_pop    = rd_req && hit[REG_RX] && enabled && !rx_empty;
    assign set_ro    = eng_rx_push && rx_full;
    assign cs_load   = wr_ctrl && new_v.en && new_master;

    // Three ways to launch the engine.
    assign st_a = tx_accept && cur_master && cur_v.smc;
    assign st_b = cs_load && new_v.smc && !cur_v.smc && !tx_empty;
    assign st_c = cs_load && new_v.xch && !cur_v.xch && !new_v.smc;

    spi_rf_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .flush(soft_clr),
        .push(tx_push), .wdata(bus_wdata), .pop(eng_tx_pop),
        .head(tx_head), .level(tx_level), .empty(tx_empty), .full(tx_full));

    spi_rf_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .flush(soft_clr),
        .push(eng_rx_push), .wdata(eng_rx_word), .pop(rx_pop),
        .head(rx_head), .level(rx_level), .empty(rx_empty), .full(rx_full));

    spi_rf_status #(.DEPTH(FIFO_DEPTH)) u_status (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .tx_level(tx_level), .rx_level(rx_level),
        .set_ro(set_ro), .set_tc(eng_done),
        .w1c_en(wr_stat), .w1c_bits({bus_wdata[STAT_TC], bus_wdata[STAT_RO]}),
        .inten(ien_q), .status(stat_word), .irq(irq));

    // Plain registers plus control, with soft reset and exchange clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            ien_q  <= '0;
            dma_q  <= '0;
            per_q  <= '0;
            tst_q  <= '0;
        end else begin
            if (wr_ctrl)       ctrl_q <= bus_wdata;
            else if (eng_done) ctrl_q[CTRL_XCH] <= 1'b0;
            if (wr_req && hit[REG_CFG]) cfg_q <= bus_wdata;
            if (wr_req && hit[REG_IEN]) ien_q <= bus_wdata;
            if (wr_req && hit[REG_DMA]) dma_q <= bus_wdata;
            if (wr_req && hit[REG_PER]) per_q <= bus_wdata;
            if (wr_req && hit[REG_TST]) tst_q <= bus_wdata;
        end
    end

    // Next chip-select pattern when a master control write lands.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_nxt[g] = (new_v.sel != SEL_W'(g));
    end

    // Chip-select and start-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cs_q    <= '1;
            start_q <= 1'b0;
        end else begin
            if (cs_load) cs_q <= cs_nxt;
            start_q <= st_a || st_b || st_c;
        end
    end

    // Read multiplexer; write-only and unmapped indices return zero.
    always_comb begin
        rd_mux = '0;
        if (hit[REG_RX])   rd_mux = !enabled ? '0 : (rx_empty ? RX_EMPTY_WORD : rx_head);
        if (hit[REG_CTRL]) rd_mux = ctrl_q;
        if (hit[REG_CFG])  rd_mux = cfg_q;
        if (hit[REG_IEN])  rd_mux = ien_q;
        if (hit[REG_DMA])  rd_mux = dma_q;
        if (hit[REG_STAT]) rd_mux = stat_word;
        if (hit[REG_PER])  rd_mux = per_q;
        if (hit[REG_TST])  rd_mux = tst_q;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
    end

    assign bus_rdata    = rdata_q;
    assign cs_n         = cs_q;
    assign xfer_start   = start_q;
    assign eng_tx_word  = tx_head;
    assign eng_tx_empty = tx_empty;

    AST_SINGLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1); // R8
    AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> $past(bus_valid && bus_write)); // R9
    AST_SOFT_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && hit[REG_CTRL] && !bus_wdata[CTRL_EN])
        |=> (stat_word == STAT_IDLE && ctrl_q == '0 && cs_n == '1 && !irq)); // R4
    AST_DISABLED_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && hit[REG_TX] && !ctrl_q[CTRL_EN] && !eng_tx_pop)
        |=> $stable(tx_level)); // R5
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R12
endmodule

// File: tb/spi_regfront_bench.sv
// Directed bench for the SPI register front end: one task per scenario.
module spi_regfront_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, xfer_start, eng_tx_empty;
    logic [3:0]  cs_n;
    logic [31:0] eng_tx_word;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_done = 1'b0;
    logic [31:0] eng_rx_word = '0;
    int checks = 0;
    int fails  = 0;

    localparam int RX = 0, TX = 1, CTRL = 2, CFG = 3, IEN = 4, DMA = 5,
                   STAT = 6, PER = 7, TST = 8, MSG = 9;

    always #4 clk = ~clk;

    spi_regfront u_spi_regfront (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cs_n(cs_n), .xfer_start(xfer_start),
        .eng_tx_word(eng_tx_word), .eng_tx_empty(eng_tx_empty),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_word(eng_rx_word), .eng_done(eng_done));

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr_addr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        wr_addr(12'(i * 4), d);
    endtask

    task automatic rd_addr(input logic [11:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd(input int i, output logic [31:0] d);
        rd_addr(12'(i * 4), d);
    endtask

    task automatic eng_push(input logic [31:0] w);
        eng_rx_push = 1'b1; eng_rx_word = w;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic eng_pop();
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R4", "cs_n after reset", {28'd0, cs_n}, 32'hF);
        chk("R4", "irq after reset", {31'd0, irq}, 0);
        chk("R9", "no start after reset", {31'd0, xfer_start}, 0);
        rd(STAT, d); chk("R4", "status after reset", d, 32'h3);
        rd(CTRL, d); chk("R4", "ctrl after reset", d, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        wr(TX, 32'h1234_5678);
        rd(RX, d); chk("R6", "rx read while disabled", d, 0);
        wr(CTRL, 32'h1);
        rd(STAT, d); chk("R5", "tx write while disabled dropped", d, 32'h3);
        rd(RX, d); chk("R6", "rx read empty marker", d, 32'hDEADBEEF);
        chk("R12", "read data holds", bus_rdata, 32'hDEADBEEF);
    endtask

    task automatic t_plain_regs();
        logic [31:0] d;
        wr(CFG, 32'hA5A5_0001); wr(DMA, 32'h0BAD_F00D);
        wr(PER, 32'h0000_7777); wr(TST, 32'h8000_0001);
        rd(CFG, d); chk("R11", "config readback", d, 32'hA5A5_0001);
        rd(DMA, d); chk("R11", "dma readback", d, 32'h0BAD_F00D);
        rd(PER, d); chk("R11", "period readback", d, 32'h0000_7777);
        rd(TST, d); chk("R11", "test readback", d, 32'h8000_0001);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(MSG, 32'hFFFF_FFFF); wr(12, 32'h1111_1111); wr(RX, 32'h2222_2222);
        wr_addr(12'h00D, 32'h5);
        rd(MSG, d); chk("R7", "message reads zero", d, 0);
        rd(12, d); chk("R7", "unmapped reads zero", d, 0);
        rd(TX, d); chk("R7", "tx data reads zero", d, 0);
        rd_addr(12'h00D, d); chk("R7", "misaligned read zero", d, 0);
        rd(CFG, d); chk("R7", "misaligned write ignored", d, 32'hA5A5_0001);
        rd(STAT, d); chk("R7", "rx write ignored", d, 32'h3);
    endtask

    task automatic t_tx_fill();
        logic [31:0] d;
        wr(TX, 32'hA000_0000);
        rd(STAT, d); chk("R1", "one tx word", d, 32'h2);
        chk("R5", "head offered", eng_tx_word, 32'hA000_0000);
        for (int k = 1; k < 32; k++) wr(TX, 32'hA000_0000 + k);
        rd(STAT, d); chk("R1", "tx at half", d, 32'h2);
        wr(TX, 32'hA000_0020);
        rd(STAT, d); chk("R1", "tx above half", d, 32'h0);
        for (int k = 33; k < 64; k++) wr(TX, 32'hA000_0000 + k);
        rd(STAT, d); chk("R1", "tx full", d, 32'h4);
        wr(TX, 32'hBBBB_BBBB);
        for (int k = 0; k < 63; k++) eng_pop();
        chk("R5", "order kept to last word", eng_tx_word, 32'hA000_003F);
        eng_pop();
        chk("R5", "write while full dropped", {31'd0, eng_tx_empty}, 1);
        rd(STAT, d); chk("R1", "tx drained", d, 32'h3);
    endtask

    task automatic t_rx_path();
        logic [31:0] d;
        eng_push(32'h11); eng_push(32'h22);
        rd(STAT, d); chk("R1", "rx non-empty", d, 32'hB);
        rd(RX, d); chk("R6", "first rx word", d, 32'h11);
        rd(RX, d); chk("R6", "second rx word", d, 32'h22);
        rd(RX, d); chk("R6", "drained rx marker", d, 32'hDEADBEEF);
        for (int k = 0; k < 64; k++) eng_push(32'h100 + k);
        rd(STAT, d); chk("R1", "rx full", d, 32'h1B);
        eng_push(32'hEEEE);
        rd(STAT, d); chk("R10", "overrun flagged", d, 32'h3B);
        rd(RX, d); chk("R10", "overrun word dropped", d, 32'h100);
        rd(STAT, d); chk("R1", "rx no longer full", d, 32'h2B);
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, d); chk("R3", "write-one clears overrun only", d, 32'h0B);
    endtask

    task automatic t_irq();
        wr(IEN, 32'h8);
        chk("R2", "irq on rx ready", {31'd0, irq}, 1);
        wr(IEN, 32'h4);
        chk("R2", "irq masked by unset bit", {31'd0, irq}, 0);
        wr(IEN, 32'h1);
        chk("R2", "irq on tx empty", {31'd0, irq}, 1);
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        wr(CTRL, 32'h0000_00F0);
        chk("R4", "irq cleared by soft reset", {31'd0, irq}, 0);
        rd(STAT, d); chk("R4", "status after soft reset", d, 32'h3);
        rd(CFG, d); chk("R4", "config cleared", d, 0);
        rd(CTRL, d); chk("R4", "ctrl cleared", d, 0);
        wr(CTRL, 32'h1);
        rd(RX, d); chk("R4", "rx queue emptied", d, 32'hDEADBEEF);
    endtask

    task automatic t_chip_select();
        wr(CTRL, 32'h0008_0041);
        chk("R8", "master selects channel 2", {28'd0, cs_n}, 32'hB);
        wr(CTRL, 32'h0004_0001);
        chk("R8", "non-master write keeps selects", {28'd0, cs_n}, 32'hB);
        chk("R9", "no start without trigger", {31'd0, xfer_start}, 0);
    endtask

    task automatic t_start();
        logic [31:0] d;
        wr(CTRL, 32'h0000_00F1);
        chk("R8", "channel 0 selected", {28'd0, cs_n}, 32'hE);
        wr(TX, 32'h5555_0001);
        chk("R9", "no start with start-on-write clear", {31'd0, xfer_start}, 0);
        eng_pop();
        wr(CTRL, 32'h0000_00F9);
        chk("R9", "start-on-write set on empty queue", {31'd0, xfer_start}, 0);
        wr(TX, 32'h5555_0002);
        chk("R9", "start on tx write", {31'd0, xfer_start}, 1);
        @(negedge clk);
        chk("R9", "start is one pulse", {31'd0, xfer_start}, 0);
        wr(CTRL, 32'h0000_00F1);
        chk("R9", "clearing start-on-write", {31'd0, xfer_start}, 0);
        wr(CTRL, 32'h0000_00F9);
        chk("R9", "start-on-write set with data", {31'd0, xfer_start}, 1);
        wr(CTRL, 32'h0000_00F1);
        wr(CTRL, 32'h0000_00F5);
        chk("R9", "start on exchange request", {31'd0, xfer_start}, 1);
        eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
        rd(CTRL, d); chk("R10", "exchange bit cleared", d, 32'h0000_00F1);
        rd(STAT, d); chk("R10", "done flag set", d, 32'h42);
        wr(STAT, 32'h40);
        rd(STAT, d); chk("R3", "done flag cleared", d, 32'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_plain_regs();
        t_reserved();
        t_tx_fill();
        t_rx_path();
        t_irq();
        t_soft_reset();
        t_chip_select();
        t_start();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule